// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is the in-order completion window of a speculative out-of-order core. Each issued instruction takes one slot in a circular buffer and gets that slot's index back as its result tag. Execution units later write results onto a writeback port under that tag. A result stays in its slot, and is visible to operand lookups, until the instruction becomes the oldest in flight. At that point it retires to the register file or to memory.

A small alias table keeps, for each architectural register, the slot of its newest in-flight producer. Operand lookups therefore return a forwarded value or a pending tag. When the table has no entry for a register, the lookup tells the caller to read the register file. A branch that was guessed wrong discards the whole window when it reaches the oldest slot. A fault noted at writeback is held in its slot and raised only when that slot becomes the oldest. All younger work is then dropped, so the fault is precise.

The depth must be a power of two. Kind encoding on `iss_kind`: 2'b00 register operation (ALU or load), 2'b01 store, 2'b10 branch.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `iss_ready` is 1, `cm_reg_we`, `cm_mem_we`, `exc_valid` and `flush` are 0, and `lk_hit` is 0 for every register.
- R2: Issued instructions receive consecutive tags starting at 0 and wrapping modulo DEPTH. Once DEPTH instructions are in flight, `iss_ready` is 0.
- R3: A writeback stores its value (and address) into the tagged slot and marks it ready. A slot written back in a cycle cannot retire in that same cycle; it retires in the following cycle at the earliest.
- R4: Only the oldest slot may retire, and at most one per cycle. A younger slot that is ready waits until every older slot has retired.
- R5: A retiring register operation drives `cm_reg_we` with its destination and value. A retiring store drives `cm_mem_we` with the written-back address and value. A correctly predicted branch retires with neither strobe.
- R6: A lookup of a register with an in-flight producer gives `lk_hit`=1 and `lk_tag` = the newest producer's tag. `lk_ready` and `lk_value` carry that producer's result once it has been written back. A register with no in-flight producer gives `lk_hit`=0.
- R7: A retiring register operation removes the alias entry only if that entry still names its own slot. A newer producer of the same register stays visible to lookups.
- R8: A branch written back with `wb_mispred`=1 raises `flush` for one cycle when it is the oldest slot. It retires, every other slot is discarded, all aliases are cleared, `iss_ready` is 0 in that cycle, and the next issue gets the tag after the branch.
- R9: A writeback with `wb_exc`=1 is only recorded. When that slot is the oldest and ready, `exc_valid`=1 with `exc_tag` set to its tag, and `flush`=1. The faulting slot performs no write, all slots are discarded, and the next issue reuses the faulting tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Instruction kind (00 reg op, 01 store, 10 branch) |
| iss_rd | input | $clog2(NREG) | Destination register for a register operation |
| iss_ready | output | 1 | A slot is free and no flush is under way |
| iss_tag | output | $clog2(DEPTH) | Tag given to the issuing instruction |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | $clog2(DEPTH) | Slot being written back |
| wb_value | input | DW | Result value or store data |
| wb_addr | input | AW | Store address |
| wb_exc | input | 1 | Instruction faulted |
| wb_mispred | input | 1 | Branch outcome differs from prediction |
| lk_reg | input | $clog2(NREG) | Register being looked up |
| lk_hit | output | 1 | Register has an in-flight producer |
| lk_ready | output | 1 | That producer's result is available |
| lk_tag | output | $clog2(DEPTH) | Tag of the newest producer |
| lk_value | output | DW | Forwarded result |
| cm_reg_we | output | 1 | Register file write on retire |
| cm_reg_idx | output | $clog2(NREG) | Register written on retire |
| cm_mem_we | output | 1 | Memory write on retire of a store |
| cm_mem_addr | output | AW | Store address on retire |
| cm_value | output | DW | Value written on retire |
| exc_valid | output | 1 | Precise fault being raised |
| exc_tag | output | $clog2(DEPTH) | Tag of the faulting instruction |
| flush | output | 1 | Window discarded this cycle |

## Verification
Writeback and retirement can land in the same cycle, and so can issue and flush. The vector table writes back a branch while a store ahead of it retires. Both must then act: the store appears on the memory strobe, and the branch retires alone one cycle later. Writebacks that arrive out of order are checked to stall at the oldest slot until it completes. Issue is attempted during the mispredict and fault cycles, and the bench judges it by the tag handed out after the window is discarded.

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH = 8,
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int AW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  input  logic [1:0]               iss_kind,
  input  logic [$clog2(NREG)-1:0]  iss_rd,
  output logic                     iss_ready,
  output logic [$clog2(DEPTH)-1:0] iss_tag,
  input  logic                     wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_tag,
  input  logic [DW-1:0]            wb_value,
  input  logic [AW-1:0]            wb_addr,
  input  logic                     wb_exc,
  input  logic                     wb_mispred,
  input  logic [$clog2(NREG)-1:0]  lk_reg,
  output logic                     lk_hit,
  output logic                     lk_ready,
  output logic [$clog2(DEPTH)-1:0] lk_tag,
  output logic [DW-1:0]            lk_value,
  output logic                     cm_reg_we,
  output logic [$clog2(NREG)-1:0]  cm_reg_idx,
  output logic                     cm_mem_we,
  output logic [AW-1:0]            cm_mem_addr,
  output logic [DW-1:0]            cm_value,
  output logic                     exc_valid,
  output logic [$clog2(DEPTH)-1:0] exc_tag,
  output logic                     flush
);
  localparam int IW = $clog2(DEPTH);
  localparam int RW = $clog2(NREG);
  localparam logic [1:0] K_REG = 2'b00;
  localparam logic [1:0] K_ST  = 2'b01;
  localparam logic [1:0] K_BR  = 2'b10;

  logic [DEPTH-1:0] e_vld, e_rdy, e_exc, e_mis;
  logic [1:0]       e_kind [DEPTH];
  logic [RW-1:0]    e_rd   [DEPTH];
  logic [DW-1:0]    e_val  [DEPTH];
  logic [AW-1:0]    e_addr [DEPTH];

  logic [NREG-1:0]  rat_v;
  logic [IW-1:0]    rat_tag [NREG];

  logic [IW:0]   hp, tp;
  logic [IW-1:0] hi, ti;
  logic          full, head_done, retire, head_mis, head_flt, iss_fire, wb_ok;

  assign hi   = hp[IW-1:0];
  assign ti   = tp[IW-1:0];
  assign full = (hp[IW] != tp[IW]) && (hi == ti);

  assign head_done = e_vld[hi] && e_rdy[hi];
  assign head_flt  = head_done && e_exc[hi];
  assign retire    = head_done && !e_exc[hi];
  assign head_mis  = retire && (e_kind[hi] == K_BR) && e_mis[hi];

  assign cm_reg_we   = retire && (e_kind[hi] == K_REG);
  assign cm_mem_we   = retire && (e_kind[hi] == K_ST);
  assign cm_reg_idx  = e_rd[hi];
  assign cm_mem_addr = e_addr[hi];
  assign cm_value    = e_val[hi];
  assign exc_valid   = head_flt;
  assign exc_tag     = hi;
  assign flush       = head_flt || head_mis;

  assign iss_ready = !full && !flush;
  assign iss_tag   = ti;
  assign iss_fire  = iss_valid && iss_ready;
  assign wb_ok     = wb_valid && e_vld[wb_tag] && !flush;

  assign lk_hit   = rat_v[lk_reg];
  assign lk_tag   = rat_tag[lk_reg];
  assign lk_ready = lk_hit && e_rdy[lk_tag];
  assign lk_value = e_val[lk_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hp    <= '0;
      tp    <= '0;
      e_vld <= '0;
      e_rdy <= '0;
      e_exc <= '0;
      e_mis <= '0;
      rat_v <= '0;
    end else if (flush) begin
      e_vld <= '0;
      rat_v <= '0;
      if (head_mis) begin
        hp <= hp + 1'b1;
        tp <= hp + 1'b1;
      end else begin
        tp <= hp;
      end
    end else begin
      if (retire) begin
        e_vld[hi] <= 1'b0;
        hp <= hp + 1'b1;
        if (e_kind[hi] == K_REG && rat_v[e_rd[hi]] && rat_tag[e_rd[hi]] == hi)
          rat_v[e_rd[hi]] <= 1'b0;
      end
      if (wb_ok) begin
        e_rdy[wb_tag]  <= 1'b1;
        e_exc[wb_tag]  <= wb_exc;
        e_mis[wb_tag]  <= wb_mispred;
        e_val[wb_tag]  <= wb_value;
        e_addr[wb_tag] <= wb_addr;
      end
      if (iss_fire) begin
        e_vld[ti]  <= 1'b1;
        e_rdy[ti]  <= 1'b0;
        e_exc[ti]  <= 1'b0;
        e_mis[ti]  <= 1'b0;
        e_kind[ti] <= iss_kind;
        e_rd[ti]   <= iss_rd;
        tp <= tp + 1'b1;
        if (iss_kind == K_REG) begin
          rat_v[iss_rd]   <= 1'b1;
          rat_tag[iss_rd] <= ti;
        end
      end
    end
  end

  // R5
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_reg_we, cm_mem_we, exc_valid}));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (hp == tp));

  // R4
  commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_reg_we || cm_mem_we) |=> (hp == $past(hp) + 1'b1));

  // R3
  wb_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_tag == hi && !e_rdy[hi]) |-> !(cm_reg_we || cm_mem_we || exc_valid));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !iss_ready);

  // R6
  lookup_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> e_vld[lk_tag]);
endmodule

// File: tb/spec_rob_tb.sv
module spec_rob_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0;
  logic [1:0]  ik = '0;
  logic [3:0]  ird = '0;
  logic        iss_ready;
  logic [2:0]  iss_tag;
  logic        wv = 1'b0;
  logic [2:0]  wt = '0;
  logic [31:0] wd = '0;
  logic [31:0] wa = '0;
  logic        wexc = 1'b0;
  logic        wmis = 1'b0;
  logic [3:0]  lreg = '0;
  logic        lk_hit, lk_ready;
  logic [2:0]  lk_tag;
  logic [31:0] lk_value;
  logic        cm_reg_we, cm_mem_we, exc_valid, flush;
  logic [3:0]  cm_reg_idx;
  logic [31:0] cm_mem_addr, cm_value;
  logic [2:0]  exc_tag;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spec_rob u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iv), .iss_kind(ik), .iss_rd(ird), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .wb_valid(wv), .wb_tag(wt), .wb_value(wd), .wb_addr(wa), .wb_exc(wexc), .wb_mispred(wmis),
    .lk_reg(lreg), .lk_hit(lk_hit), .lk_ready(lk_ready), .lk_tag(lk_tag), .lk_value(lk_value),
    .cm_reg_we(cm_reg_we), .cm_reg_idx(cm_reg_idx), .cm_mem_we(cm_mem_we),
    .cm_mem_addr(cm_mem_addr), .cm_value(cm_value),
    .exc_valid(exc_valid), .exc_tag(exc_tag), .flush(flush)
  );

  typedef struct packed {
    logic       iv;
    logic [1:0] k;
    logic [3:0] rd;
    logic       wv;
    logic [2:0] wt;
    logic [15:0] wd;
    logic [2:0] et;
    logic       er;
    logic       em;
    logic       ef;
    logic [15:0] ev;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 2'd0, 4'd3, 1'b0, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 2'd1, 4'd0, 1'b0, 3'd0, 16'h0000, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 2'd2, 4'd0, 1'b0, 3'd0, 16'h0000, 3'd2, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 4'd0, 1'b1, 3'd1, 16'h0055, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 4'd0, 1'b1, 3'd0, 16'h0011, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 4'd0, 1'b0, 3'd0, 16'h0000, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0011},
    '{1'b0, 2'd0, 4'd0, 1'b1, 3'd2, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0055},
    '{1'b0, 2'd0, 4'd0, 1'b0, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 4'd0, 1'b0, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    iv = 1'b0; wv = 1'b0; wexc = 1'b0; wmis = 1'b0;
  endtask

  task automatic set_iss(input logic [1:0] k, input logic [3:0] rd);
    iv = 1'b1; ik = k; ird = rd;
  endtask

  task automatic set_wb(input logic [2:0] t, input logic [31:0] d, input logic e, input logic m);
    wv = 1'b1; wt = t; wd = d; wa = {d[27:0], 4'h0}; wexc = e; wmis = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    lreg = 4'd3;
    #1;
    // R1 reset state
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 cm_reg_we", cm_reg_we, 0);
    chk("R1 cm_mem_we", cm_mem_we, 0);
    chk("R1 flush", flush, 0);
    chk("R1 exc_valid", exc_valid, 0);
    chk("R1 lk_hit", lk_hit, 0);

    // R3 R4 R5 table: issue, out-of-order writeback, in-order retire
    for (int i = 0; i < 9; i++) begin
      iv = VECS[i].iv; ik = VECS[i].k; ird = VECS[i].rd;
      wv = VECS[i].wv; wt = VECS[i].wt; wd = {16'h0, VECS[i].wd};
      wa = {12'h0, VECS[i].wd, 4'h0};
      #1;
      if (VECS[i].iv) chk("R2 table iss_tag", iss_tag, VECS[i].et);
      chk("R4 table cm_reg_we", cm_reg_we, VECS[i].er);
      chk("R5 table cm_mem_we", cm_mem_we, VECS[i].em);
      chk("R3 table flush", flush, VECS[i].ef);
      if (VECS[i].er) begin
        chk("R5 table cm_reg_idx", cm_reg_idx, 3);
        chk("R5 table cm_value", cm_value, VECS[i].ev);
      end
      if (VECS[i].em) begin
        chk("R5 table cm_mem_addr", cm_mem_addr, {12'h0, VECS[i].ev, 4'h0});
        chk("R5 table cm_value", cm_value, VECS[i].ev);
      end
      tick();
    end

    // R6 R7 lookup and alias handling; head and tail now at 3
    set_iss(2'd0, 4'd5); #1 chk("R2 iss_tag", iss_tag, 3); tick();
    set_iss(2'd0, 4'd5); #1 chk("R2 iss_tag", iss_tag, 4); tick();
    lreg = 4'd5; #1;
    chk("R6 lk_hit pending", lk_hit, 1);
    chk("R6 lk_ready pending", lk_ready, 0);
    chk("R6 lk_tag newest", lk_tag, 4);
    set_wb(3'd4, 32'hAA, 0, 0); tick();
    chk("R6 lk_ready", lk_ready, 1);
    chk("R6 lk_value", lk_value, 32'hAA);
    chk("R4 younger waits", cm_reg_we, 0);
    set_wb(3'd3, 32'h33, 0, 0); tick();
    chk("R5 cm_reg_we", cm_reg_we, 1);
    chk("R5 cm_reg_idx", cm_reg_idx, 5);
    chk("R5 cm_value", cm_value, 32'h33);
    tick();
    chk("R7 newer kept hit", lk_hit, 1);
    chk("R7 newer kept tag", lk_tag, 4);
    chk("R4 next retire", cm_value, 32'hAA);
    tick();
    chk("R7 cleared", lk_hit, 0);
    lreg = 4'd9; #1 chk("R6 no producer", lk_hit, 0);

    // R2 fill to capacity with wrap; head and tail at 5
    set_iss(2'd2, 4'd0); #1 chk("R2 wrap tag", iss_tag, 5); tick();
    for (int j = 1; j < 8; j++) begin
      set_iss(2'd0, 4'd1); #1 chk("R2 wrap tag", iss_tag, (5 + j) % 8); tick();
    end
    chk("R2 full", iss_ready, 0);

    // R8 mispredicted branch at head
    set_wb(3'd5, 32'h0, 0, 1); #1 chk("R8 no early flush", flush, 0); tick();
    set_iss(2'd0, 4'd7);
    #1;
    chk("R8 flush", flush, 1);
    chk("R8 no exc", exc_valid, 0);
    chk("R8 issue blocked", iss_ready, 0);
    chk("R8 no reg write", cm_reg_we, 0);
    tick();
    lreg = 4'd1; #1;
    chk("R8 flush pulse", flush, 0);
    chk("R8 ready again", iss_ready, 1);
    chk("R8 alias cleared", lk_hit, 0);
    lreg = 4'd7; #1 chk("R8 blocked issue dropped", lk_hit, 0);
    chk("R8 next tag", iss_tag, 6);

    // R9 deferred fault
    set_iss(2'd0, 4'd2); tick();
    set_iss(2'd0, 4'd2); tick();
    set_wb(3'd7, 32'h77, 1, 0); tick();
    chk("R9 not raised early", exc_valid, 0);
    chk("R9 no early flush", flush, 0);
    set_wb(3'd6, 32'h66, 0, 0); tick();
    chk("R9 older retires", cm_reg_we, 1);
    chk("R9 older value", cm_value, 32'h66);
    chk("R9 still held", exc_valid, 0);
    tick();
    chk("R9 exc_valid", exc_valid, 1);
    chk("R9 exc_tag", exc_tag, 7);
    chk("R9 flush", flush, 1);
    chk("R9 no write", cm_reg_we, 0);
    tick();
    lreg = 4'd2; #1;
    chk("R9 tag reused", iss_tag, 7);
    chk("R9 ready", iss_ready, 1);
    chk("R9 alias cleared", lk_hit, 0);
    chk("R9 exc pulse", exc_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule